// File: doc/BRIEF.md
# Core-Local Timer and Software-Interrupt Unit

This unit gives a group of processor harts a shared 64-bit time counter. It also gives each hart a 64-bit compare register and a software-interrupt bit. Software reaches all of this through a plain 32-bit register port, which has an address, write data, a write strobe, a read strobe and registered read data. The time counter starts at zero. It counts up by one on every clock cycle in which the tick-enable input is high. Software can read it but cannot change it.

Each hart has its own timer-interrupt line. The line is level-sensitive: it is high whenever the hart's compare value is at or below the current time. If software writes a compare value that is already in the past, the line therefore fires at once. Software writes a 64-bit compare value as two separate 32-bit halves, and each half write leaves the other half unchanged. Each hart's software-interrupt line follows bit 0 of the last value written to that hart's software-interrupt word.

The parameters set the number of harts, the address width and the base offsets of the three register regions. Each base offset must be a multiple of 8. The layout of each region is:
- Software-interrupt words: one 32-bit word per hart, 4 bytes apart.
- Compare slots: 8 bytes per hart, with the low half first.
- Time counter: low word at the time base, high word 4 bytes above it.

Top module: `core_timer_unit`

## Requirements
- R1: The time counter resets to 0. It increases by exactly 1 on each clock edge where `tick_en` is 1, holds its value otherwise, and wraps at 2^64.
- R2: A read of `TIME_BASE` returns time bits 31:0, and a read of `TIME_BASE+4` returns bits 63:32. The value is the one in effect at the read edge. `reg_rdata` presents read data in the cycle after `reg_re` and is 0 in every cycle that follows a cycle without `reg_re`.
- R3: Writes to either time word have no effect on the time counter.
- R4: The software-interrupt word of hart h is at `SWI_BASE+4*h`. A write sets `soft_irq[h]` to bit 0 of the write data, and the output changes in the cycle after the write. A read returns 1 in bit 0 if the bit is set, with all other bits 0.
- R5: Hart h's compare register resets to 0. Its bits 31:0 are at `CMP_BASE+8*h` and its bits 63:32 are at `CMP_BASE+8*h+4`, and both halves read back what was written.
- R6: A write to the low compare word replaces bits 31:0 and keeps bits 63:32. A write to the high word replaces bits 63:32 and keeps bits 31:0.
- R7: `timer_irq[h]` in a cycle equals (compare(h) <= time) as those values stood one edge earlier. A compare value written in the past therefore asserts the line, and a value written in the future deasserts it.
- R8: Accesses to misaligned addresses, to addresses outside the three regions, or to hart slots at or beyond `NUM_HARTS` read as 0. Writes to those addresses change nothing.
- R9: While reset is asserted, all outputs are 0. Because compare and time both start at 0, every `timer_irq` line rises on the first edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Advances the time counter by one when high |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data, one cycle after `reg_re` |
| timer_irq | output | NUM_HARTS | Per-hart timer interrupt |
| soft_irq | output | NUM_HARTS | Per-hart software interrupt |

## Verification
The compare function is exercised with four kinds of compare value:
- The reset value, which tells whether the reset state already counts as due.
- A value a few dozen ticks ahead of the time counter, which shows the interrupt line dropping and then rising on the exact tick it becomes due.
- A value whose high half is set far in the future while its low half lies in the past, which separates a full 64-bit comparison from a 32-bit one.
- A value written in the past, which confirms the interrupt fires at once.

Half writes are issued in both orders, to show that each half write keeps the other half. Accesses to unused slots, misaligned addresses and the time words show whether the address decode leaks into neighbouring registers.

// File: rtl/core_timer_unit.sv
module core_timer_unit #(
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned SWI_BASE  = 32'h0000,
  parameter int unsigned CMP_BASE  = 32'h4000,
  parameter int unsigned TIME_BASE = 32'hBFF8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  input  logic                 reg_we,
  input  logic                 reg_re,
  output logic [31:0]          reg_rdata,
  output logic [NUM_HARTS-1:0] timer_irq,
  output logic [NUM_HARTS-1:0] soft_irq
);

  localparam logic [ADDR_W-1:0] TIME_LO = ADDR_W'(TIME_BASE);
  localparam logic [ADDR_W-1:0] TIME_HI = ADDR_W'(TIME_BASE + 4);

  function automatic logic [ADDR_W-1:0] swi_at(int unsigned h);
    return ADDR_W'(SWI_BASE + 4 * h);
  endfunction

  function automatic logic [ADDR_W-1:0] cmp_at(int unsigned h, int unsigned half);
    return ADDR_W'(CMP_BASE + 8 * h + 4 * half);
  endfunction

  logic [63:0] now_q;
  logic [NUM_HARTS-1:0][63:0] cmp_q;
  logic [31:0] rd_val;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       now_q <= '0;
    else if (tick_en) now_q <= now_q + 64'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmp_q    <= '0;
      soft_irq <= '0;
    end else if (reg_we) begin
      for (int unsigned h = 0; h < NUM_HARTS; h++) begin
        if (reg_addr == swi_at(h))    soft_irq[h]         <= reg_wdata[0];
        if (reg_addr == cmp_at(h, 0)) cmp_q[h][31:0]      <= reg_wdata;
        if (reg_addr == cmp_at(h, 1)) cmp_q[h][63:32]     <= reg_wdata;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) timer_irq <= '0;
    else
      for (int unsigned h = 0; h < NUM_HARTS; h++)
        timer_irq[h] <= (cmp_q[h] <= now_q);

  always_comb begin
    rd_val = '0;
    if (reg_addr == TIME_LO) rd_val = now_q[31:0];
    if (reg_addr == TIME_HI) rd_val = now_q[63:32];
    for (int unsigned h = 0; h < NUM_HARTS; h++) begin
      if (reg_addr == swi_at(h))    rd_val = {31'd0, soft_irq[h]};
      if (reg_addr == cmp_at(h, 0)) rd_val = cmp_q[h][31:0];
      if (reg_addr == cmp_at(h, 1)) rd_val = cmp_q[h][63:32];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= reg_re ? rd_val : 32'd0;

  a_r1_tick_advance: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> now_q == $past(now_q) + 64'd1);

  a_r1_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(now_q));

  a_r3_time_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !tick_en && (reg_addr == TIME_LO || reg_addr == TIME_HI)) |=> $stable(now_q));

  a_r2_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_re |=> reg_rdata == 32'd0);

  a_r2_time_lo_read: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && reg_addr == TIME_LO) |=> reg_rdata == $past(now_q[31:0]));

  for (genvar g = 0; g < NUM_HARTS; g++) begin : g_hart_chk
    a_r4_soft_changes_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(soft_irq[g]) |-> $past(reg_we));

    a_r4_soft_readback: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_re && reg_addr == swi_at(g)) |=> reg_rdata == {31'd0, $past(soft_irq[g])});

    a_r5_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_we |=> $stable(cmp_q[g]));

    a_r7_rise_when_due: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timer_irq[g]) |-> $past(cmp_q[g] <= now_q));
  end

endmodule

// File: tb/tb_core_timer_unit.sv
`timescale 1ns/1ps
module tb_core_timer_unit;
  localparam int NH = 4;
  localparam int SB = 'h0000;
  localparam int CB = 'h4000;
  localparam int TB = 'hBFF8;

  logic clk = 0;
  always #2 clk = ~clk;

  logic        rst_n = 0;
  logic        tick_en = 0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 0, reg_re = 0;
  logic [31:0] reg_rdata;
  logic [NH-1:0] timer_irq, soft_irq;

  core_timer_unit #(.NUM_HARTS(NH), .ADDR_W(16), .SWI_BASE(SB), .CMP_BASE(CB), .TIME_BASE(TB)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata), .timer_irq(timer_irq), .soft_irq(soft_irq));

  logic [63:0] m_time = 0;
  logic [63:0] m_cmp [NH];
  logic [NH-1:0] m_swi = 0, m_tirq = 0;
  logic [31:0] m_rdata = 0;
  int vectors = 0, errors = 0;
  string phase = "R9";
  bit done = 0;

  initial for (int h = 0; h < NH; h++) m_cmp[h] = 0;

  function automatic logic [31:0] m_read(logic [15:0] a);
    if (a == 16'(TB))     return m_time[31:0];
    if (a == 16'(TB + 4)) return m_time[63:32];
    for (int h = 0; h < NH; h++) begin
      if (a == 16'(SB + 4*h))     return {31'd0, m_swi[h]};
      if (a == 16'(CB + 8*h))     return m_cmp[h][31:0];
      if (a == 16'(CB + 8*h + 4)) return m_cmp[h][63:32];
    end
    return 0;
  endfunction

  always @(posedge clk) begin
    logic [31:0] nrd;
    logic [NH-1:0] nt;
    if (!rst_n) begin
      m_time = 0; m_swi = 0; m_tirq = 0; m_rdata = 0;
      for (int h = 0; h < NH; h++) m_cmp[h] = 0;
    end else begin
      nrd = reg_re ? m_read(reg_addr) : 32'd0;
      for (int h = 0; h < NH; h++) nt[h] = (m_cmp[h] <= m_time);
      if (reg_we)
        for (int h = 0; h < NH; h++) begin
          if (reg_addr == 16'(SB + 4*h))     m_swi[h] = reg_wdata[0];
          if (reg_addr == 16'(CB + 8*h))     m_cmp[h][31:0] = reg_wdata;
          if (reg_addr == 16'(CB + 8*h + 4)) m_cmp[h][63:32] = reg_wdata;
        end
      if (tick_en) m_time = m_time + 1;
      m_rdata = nrd;
      m_tirq = nt;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk(phase, 64'(reg_rdata), 64'(m_rdata));
    chk(phase == "R9" ? "R9" : "R7", 64'(timer_irq), 64'(m_tirq));
    chk(phase == "R9" ? "R9" : "R4", 64'(soft_irq), 64'(m_swi));
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); reg_addr = 16'(a); reg_wdata = d; reg_we = 1;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(int a);
    @(negedge clk); reg_addr = 16'(a); reg_re = 1;
    @(negedge clk); reg_re = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    phase = "R9";
    idle(3);
    rst_n = 1;
    idle(3);
    phase = "R1"; tick_en = 1;
    idle(5);
    phase = "R2";
    rd(TB); rd(TB + 4); idle(2);
    tick_en = 0; rd(TB); tick_en = 1;
    phase = "R3";
    wr(TB, 32'hFFFF_FFFF); wr(TB + 4, 32'h1234_5678);
    rd(TB); rd(TB + 4);
    phase = "R4";
    wr(SB + 0, 32'd1); wr(SB + 8, 32'hFFFF_FFFF);
    rd(SB + 0); rd(SB + 8); rd(SB + 4);
    wr(SB + 0, 32'hFFFF_FFFE); rd(SB + 0);
    phase = "R5";
    wr(CB + 8, 32'(m_time) + 32'd40); wr(CB + 12, 32'd0);
    rd(CB + 8); rd(CB + 12);
    phase = "R7";
    idle(60);
    phase = "R6";
    wr(CB + 16, 32'd3); wr(CB + 20, 32'd5);
    rd(CB + 16); rd(CB + 20);
    wr(CB + 16, 32'd0); rd(CB + 16); rd(CB + 20);
    idle(4);
    phase = "R7";
    wr(CB + 20, 32'd0); idle(4);
    wr(CB + 24, 32'hFFFF_FFFF); wr(CB + 28, 32'hFFFF_FFFF); idle(4);
    wr(CB + 28, 32'd0); idle(4);
    phase = "R8";
    wr(SB + 4*NH, 32'd1); wr(CB + 8*NH, 32'h55); wr(CB + 8*NH + 4, 32'h66);
    wr(SB + 1, 32'd1); wr(CB + 2, 32'hAA); wr(TB + 8, 32'h77);
    rd(SB + 4*NH); rd(CB + 8*NH); rd(CB + 8*NH + 4); rd(SB + 1); rd(CB + 2);
    rd(TB + 8); rd(TB + 2); rd(CB + 0); rd(SB + 4);
    idle(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule